// File: doc/BRIEF.md
# Programmable interval timer channel

A single 16-bit down-counting timer channel behind an 8-bit register interface with two addresses: a control port and a data port. A control byte written to the control port selects the counting mode and the order in which the two bytes of the count are transferred. The next data-port writes then supply the start value. The channel can run as a terminal-count flag, as a periodic rate generator, or as a single strobe after a countdown. A latch command freezes a snapshot of the count so software can read it without tearing.

The counter steps once per `clk` edge while it is running. The output line `tmr_out` is the event or interrupt line. Reads return the byte selected by the current read pointer on `rdata`; this value is valid while `rd_en` is high, and the pointer moves on at the clock edge.

Top module: `pit_channel`

## Requirements
- R1: After reset, `tmr_out` is 0, the counter is stopped at 0, the access order is two-byte (low byte first) and `rdata` shows 0.
- R2: A control-port write is accepted only if bits 7:6 equal `CHAN_SEL` (0 by default); otherwise it has no effect at all. Bits 5:4 give the access order (00 latch command, 01 low byte only, 10 high byte only, 11 low then high). Bits 3:1 give the mode: x10 is periodic, 100 is strobe, and any other code is terminal-count. Bit 0 is ignored, so counting is always binary.
- R3: An accepted control word with a nonzero access field stops the counter, holds its value and restarts both byte sequences. It drives `tmr_out` low in terminal-count mode and high in the other modes. No event occurs until a new count is loaded.
- R4: In two-byte order the count takes effect at the edge of the high-byte write. In single-byte orders it takes effect at the edge of that one write, and the other byte is zero. The count decrements from the following edge.
- R5: A loaded count of 0 acts as 65536.
- R6: In terminal-count mode, loading a count N drives `tmr_out` low. `tmr_out` rises at the N-th edge after the load and stays high until the next load or control word; the count is not reloaded.
- R7: In periodic mode with N of 2 or more, `tmr_out` is low for exactly one clock, when the count is 1. The counter then reloads N, so the period is N clocks.
- R8: In strobe mode, `tmr_out` is high after the load and goes low for one clock at the N-th edge after the load. This happens only once per load.
- R9: A latch command captures the count at its edge without affecting counting. Reads then return the captured value in the current access order, and the snapshot is released after the last byte of that order.
- R10: A latch command while a snapshot is still pending is ignored.
- R11: Without a pending snapshot, each data-port read returns the byte of the live count at the time of that read.
- R12: Only a data-port read (`rd_en` with `addr` 0) advances the read pointer. A read with `addr` 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count step per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe; advances the read pointer at the edge |
| addr | input | 1 | 0 selects the data port, 1 the control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Byte selected by the current read pointer |
| tmr_out | output | 1 | Timer output / interrupt line |

## Verification
A corrupted count register shows on `rdata` in the same cycle, because the low byte of the live count is visible whenever no snapshot is pending. The bench compares it against the arithmetic value every clock. A wrong mode or sticky flag shows on `tmr_out` no later than the first terminal count after the load, which is at most N clocks away. A stuck read pointer or latch flag shows on the very next data-port read as a wrong byte or as a stale value.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        MD_TC_INT = 2'd0,
        MD_RATE   = 2'd1,
        MD_STROBE = 2'd2
    } pit_mode_e;

    typedef enum logic [1:0] {
        AC_LATCH = 2'd0,
        AC_LO    = 2'd1,
        AC_HI    = 2'd2,
        AC_LOHI  = 2'd3
    } pit_acc_e;

    // Mode field x10 is periodic, 100 is strobe, everything else terminal-count
    function automatic pit_mode_e decode_mode(input logic [2:0] f);
        if (f[1:0] == 2'b10)   return MD_RATE;
        else if (f == 3'b100)  return MD_STROBE;
        else                   return MD_TC_INT;
    endfunction

endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_SEL = 2'd0
) (
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:1] cw_bits,
    output logic       cw_valid,
    output logic       latch_cmd,
    output logic       data_wr,
    output pit_acc_e   acc_new,
    output pit_mode_e  mode_new
);
    logic ctl_hit;

    always_comb begin
        ctl_hit   = wr_en && addr && (cw_bits[7:6] == CHAN_SEL);
        acc_new   = pit_acc_e'(cw_bits[5:4]);
        mode_new  = decode_mode(cw_bits[3:1]);
        cw_valid  = ctl_hit && (cw_bits[5:4] != 2'b00);
        latch_cmd = ctl_hit && (cw_bits[5:4] == 2'b00);
        data_wr   = wr_en && !addr;
    end
endmodule

// File: rtl/pit_byte_io.sv
module pit_byte_io
    import pit_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_valid,
    input  pit_acc_e          acc_new,
    input  logic              latch_cmd,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_fire,
    input  logic [CNT_W-1:0]  cnt,
    output logic              load_go,
    output logic [CNT_W-1:0]  load_val,
    output logic [DATA_W-1:0] rdata,
    output logic              latched,
    output logic [CNT_W-1:0]  latch_val
);
    typedef struct packed {
        pit_acc_e          acc;
        logic              wr_hi;
        logic              rd_hi;
        logic [DATA_W-1:0] lo_hold;
        logic              latched;
        logic [CNT_W-1:0]  snap;
    } io_st_t;

    io_st_t st_d, st_q;
    logic [CNT_W-1:0] src;
    logic             show_hi;
    logic             last_rd;

    always_comb begin
        st_d     = st_q;
        load_go  = 1'b0;
        load_val = '0;
        last_rd  = (st_q.acc != AC_LOHI) || st_q.rd_hi;
        if (cw_valid) begin
            st_d.acc     = acc_new;
            st_d.wr_hi   = 1'b0;
            st_d.rd_hi   = 1'b0;
            st_d.latched = 1'b0;
        end else begin
            if (data_wr) begin
                case (st_q.acc)
                    AC_LO: begin
                        load_go  = 1'b1;
                        load_val = {{DATA_W{1'b0}}, wdata};
                    end
                    AC_HI: begin
                        load_go  = 1'b1;
                        load_val = {wdata, {DATA_W{1'b0}}};
                    end
                    default: begin
                        if (!st_q.wr_hi) begin
                            st_d.lo_hold = wdata;
                            st_d.wr_hi   = 1'b1;
                        end else begin
                            load_go     = 1'b1;
                            load_val    = {wdata, st_q.lo_hold};
                            st_d.wr_hi  = 1'b0;
                        end
                    end
                endcase
            end
            if (rd_fire) begin
                if (st_q.acc == AC_LOHI) st_d.rd_hi = !st_q.rd_hi;
                if (last_rd)             st_d.latched = 1'b0;
            end
            // evaluated after the read so a fresh snapshot is not released at once
            if (latch_cmd && !st_q.latched) begin
                st_d.latched = 1'b1;
                st_d.snap    = cnt;
            end
        end

        src     = st_q.latched ? st_q.snap : cnt;
        show_hi = (st_q.acc == AC_HI) || ((st_q.acc == AC_LOHI) && st_q.rd_hi);
        rdata   = show_hi ? src[CNT_W-1 -: DATA_W] : src[DATA_W-1:0];
        latched   = st_q.latched;
        latch_val = st_q.snap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.acc     <= AC_LOHI;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_valid,
    input  pit_mode_e        mode_new,
    input  logic             load_go,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output pit_mode_e        mode,
    output logic             tmr_out
);
    typedef struct packed {
        pit_mode_e        mode;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             out;
        logic             done;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     tc;

    always_comb begin
        st_d = st_q;
        tc   = st_q.armed && (st_q.cnt == CNT_W'(1));
        if (cw_valid) begin
            st_d.mode  = mode_new;
            st_d.armed = 1'b0;
            st_d.done  = 1'b0;
            st_d.out   = (mode_new != MD_TC_INT);
        end else if (load_go) begin
            st_d.cnt    = load_val;
            st_d.reload = load_val;
            st_d.armed  = 1'b1;
            st_d.done   = 1'b0;
            case (st_q.mode)
                MD_RATE:   st_d.out = (load_val != CNT_W'(1));
                MD_STROBE: st_d.out = 1'b1;
                default:   st_d.out = 1'b0;
            endcase
        end else if (st_q.armed) begin
            case (st_q.mode)
                MD_RATE: begin
                    st_d.cnt = tc ? st_q.reload : st_q.cnt - CNT_W'(1);
                    st_d.out = (st_d.cnt != CNT_W'(1));
                end
                MD_STROBE: begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                    st_d.out = !(tc && !st_q.done);
                    if (tc) st_d.done = 1'b1;
                end
                default: begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                    if (tc) st_d.out = 1'b1;
                end
            endcase
        end
        cnt     = st_q.cnt;
        armed   = st_q.armed;
        mode    = st_q.mode;
        tmr_out = st_q.out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_TC_INT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter logic [1:0] CHAN_SEL = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tmr_out
);
    localparam int CNT_W = 2 * DATA_W;

    logic             cw_valid, latch_cmd, data_wr, rd_fire;
    pit_acc_e         acc_new;
    pit_mode_e        mode_new, core_mode;
    logic             load_go, armed, latched;
    logic [CNT_W-1:0] load_val, cnt_val, latch_val;

    assign rd_fire = rd_en && !addr;

    pit_ctrl_dec #(.CHAN_SEL(CHAN_SEL)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .cw_bits   (wdata[7:1]),
        .cw_valid  (cw_valid),
        .latch_cmd (latch_cmd),
        .data_wr   (data_wr),
        .acc_new   (acc_new),
        .mode_new  (mode_new)
    );

    pit_byte_io #(.DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw_valid  (cw_valid),
        .acc_new   (acc_new),
        .latch_cmd (latch_cmd),
        .data_wr   (data_wr),
        .wdata     (wdata),
        .rd_fire   (rd_fire),
        .cnt       (cnt_val),
        .load_go   (load_go),
        .load_val  (load_val),
        .rdata     (rdata),
        .latched   (latched),
        .latch_val (latch_val)
    );

    pit_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw_valid (cw_valid),
        .mode_new (mode_new),
        .load_go  (load_go),
        .load_val (load_val),
        .cnt      (cnt_val),
        .armed    (armed),
        .mode     (core_mode),
        .tmr_out  (tmr_out)
    );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cw_valid,
    input logic [2:0]       mode_field,
    input logic             load_go,
    input logic             rd_fire,
    input logic             armed,
    input pit_mode_e        mode,
    input logic [CNT_W-1:0] cnt,
    input logic             latched,
    input logic [CNT_W-1:0] latch_val,
    input logic             tmr_out
);
    AST_CW_TCINT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && mode_field == 3'b000) |=> !tmr_out); // R3

    AST_CW_RATE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && mode_field[1:0] == 2'b10) |=> tmr_out); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !load_go) |=> $stable(cnt)); // R3

    AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TC_INT && tmr_out && !cw_valid && !load_go) |=> tmr_out); // R6

    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STROBE && !tmr_out && !cw_valid) |=> tmr_out); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !cw_valid && !rd_fire) |=> (latched && $stable(latch_val))); // R9
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cw_valid   (cw_valid),
    .mode_field (wdata[3:1]),
    .load_go    (load_go),
    .rd_fire    (rd_fire),
    .armed      (armed),
    .mode       (core_mode),
    .cnt        (cnt_val),
    .latched    (latched),
    .latch_val  (latch_val),
    .tmr_out    (tmr_out)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tmr_out;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] lo, hi;

    always #4 clk = ~clk;

    pit_channel u_pit_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every access task starts and ends at a falling edge and spans one rising edge
    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 1'b0;
    endtask

    task automatic load16(input int n);
        wr(1'b0, n[7:0]);
        wr(1'b0, n[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 out after reset", tmr_out, 0);
        check("R1 rdata after reset", rdata, 0);

        // terminal-count mode sweep
        for (int n = 1; n <= 6; n++) begin
            wr(1'b1, 8'h30);
            check("R3 cw tc-mode out low", tmr_out, 0);
            load16(n);
            for (int k = 1; k <= n + 3; k++) begin
                @(negedge clk);
                check("R6 tc-mode out", tmr_out, (k >= n) ? 1 : 0);
                check("R4 live count low byte", rdata, (n - k) & 255);
            end
        end
        load16(3);
        check("R6 reload drives out low", tmr_out, 0);
        repeat (3) @(negedge clk);
        check("R6 out high after reload count", tmr_out, 1);

        // periodic mode sweep
        for (int n = 2; n <= 7; n++) begin
            wr(1'b1, 8'h34);
            check("R3 cw periodic out high", tmr_out, 1);
            load16(n);
            for (int k = 0; k <= 3 * n; k++) begin
                check("R7 periodic out", tmr_out, ((k % n) != n - 1) ? 1 : 0);
                check("R7 periodic count", rdata, (n - (k % n)) & 255);
                @(negedge clk);
            end
        end

        // strobe mode sweep
        for (int n = 1; n <= 6; n += 2) begin
            wr(1'b1, 8'h38);
            check("R3 cw strobe out high", tmr_out, 1);
            load16(n);
            for (int k = 0; k <= n + 4; k++) begin
                check("R8 strobe out", tmr_out, (k != n) ? 1 : 0);
                @(negedge clk);
            end
        end

        // zero count is 65536
        wr(1'b1, 8'h30);
        load16(0);
        repeat (65535) @(negedge clk);
        check("R5 out still low at 65535", tmr_out, 0);
        @(negedge clk);
        check("R5 out high at 65536", tmr_out, 1);

        // low-byte-only order, bit 0 set, foreign channel word mid-run
        wr(1'b1, 8'h15);
        wr(1'b0, 8'h05);
        for (int k = 0; k <= 14; k++) begin
            check("R2 periodic out with foreign cw", tmr_out, ((k % 5) != 4) ? 1 : 0);
            check("R4 low-only count", rdata, 5 - (k % 5));
            if (k == 7) wr(1'b1, 8'h70);
            else        @(negedge clk);
        end

        // high-byte-only order
        wr(1'b1, 8'h24);
        wr(1'b0, 8'h01);
        check("R4 high-only count byte at load", rdata, 8'h01);
        @(negedge clk);
        check("R4 high-only count byte after one step", rdata, 8'h00);
        check("R4 high-only out", tmr_out, 1);

        // live read tearing
        wr(1'b1, 8'h34);
        load16(16'h0300);
        rd(1'b0, lo);
        rd(1'b0, hi);
        check("R11 torn live read", {hi, lo}, 16'h0200);

        // latch capture, ignored second latch, release
        repeat (5) @(negedge clk);
        wr(1'b1, 8'h00);
        repeat (3) @(negedge clk);
        wr(1'b1, 8'h00);
        rd(1'b0, lo);
        rd(1'b0, hi);
        check("R9 latched value", {hi, lo}, 16'h02F9);
        check("R10 second latch ignored", {hi, lo}, 16'h02F9);
        rd(1'b0, lo);
        check("R9 released, live count low", lo, 8'hF2);
        rd(1'b0, hi);
        check("R11 live count high", hi, 8'h02);

        // control word stops the channel
        wr(1'b1, 8'h34);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R3 stopped out stays high", tmr_out, 1);
        end
        rd(1'b1, lo);
        rd(1'b0, lo);
        check("R12 control-address read no advance, low byte", lo, 8'hF0);
        rd(1'b0, hi);
        check("R3 held count high byte", hi, 8'h02);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule